// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block walks a small ring of transmit descriptors held in an internal descriptor store and feeds each described buffer, one byte at a time, to a downstream MAC transmit engine. Software loads the descriptors through a host write port, sets the global enable and strobes the descriptor-active input. The sequencer then fetches descriptors in ring order and streams every byte of each buffer. It flags the final byte of a frame and passes along the per-descriptor request for a 32-bit CRC. When a buffer has been sent it writes the descriptor back and releases ownership.

Ownership is released in two ways. A buffer in the middle of a frame only loses its ready bit, and the next descriptor is fetched at once. The final buffer of a frame is held until the engine reports that the frame is complete. The engine's frame status is then written into the descriptor together with the ready-bit clear. A graceful-stop request parks the sequencer at the next frame boundary and raises a one-cycle completion pulse. A frame that is cut short by a collision also counts as a frame boundary, because the engine reports it as a completed frame with a status code. Clearing the request resumes with the next descriptor.

Top module: `txbd_sequencer`

## Requirements
- R1: After reset txValid, txLast, bufIrq, frmIrq and stopDone are 0 and every descriptor reads back as 0.
- R2: No descriptor is fetched and no byte is offered unless enable is 1 and a descriptActive strobe has been seen since the last halt. Neither condition alone starts a transfer.
- R3: Each buffer is streamed in order. Byte k is taken from memAddr = addr + k, txData equals memData, and memAddr and txValid hold while txReady is 0.
- R4: txLast is 1 only on the final byte of a buffer whose last bit is set. txCrc equals the descriptor's CRC bit for every byte of that buffer.
- R5: At the end of a buffer whose last bit is clear, only the ready bit (bit 31) is cleared, with the status field left unchanged, and the next descriptor is fetched without waiting for frmDone.
- R6: At the end of a buffer whose last bit is set, no further byte is offered until frmDone. On frmDone, frmStat is written into the status field (bits 27:24) and the ready bit is cleared.
- R7: The descriptor word has ready at bit 31, wrap at bit 30, last at bit 29, CRC at bit 28, status at bits 27:24, length in bytes (at least 1) at bits 23:16, and buffer address at bits 15:0. After a descriptor with the wrap bit is written back, the next fetch uses index 0. Otherwise the index advances by one modulo 8.
- R8: If a fetched descriptor's ready bit is 0, the sequencer halts and offers nothing more until descActive is strobed again.
- R9: bufIrq pulses once per written-back buffer only while bufIrqEn is 1. frmIrq pulses once per completed frame only while frmIrqEn is 1.
- R10: Raising gracefulStop while no frame is in progress produces one stopDone pulse within 3 cycles, and no transfer starts while it stays high.
- R11: Raising gracefulStop during a frame lets every remaining buffer of that frame finish. stopDone pulses only after frmDone, and no later descriptor is started. Clearing gracefulStop resumes with the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global transmit enable |
| descActive | input | 1 | Strobe: ready descriptors are available |
| gracefulStop | input | 1 | Graceful-stop request level |
| bufIrqEn | input | 1 | Mask enable for the buffer-done event |
| frmIrqEn | input | 1 | Mask enable for the frame-done event |
| hostWrEn | input | 1 | Host descriptor write strobe |
| hostWrIdx | input | 3 | Host write index |
| hostWrData | input | 32 | Host descriptor word |
| hostRdIdx | input | 3 | Host read index |
| hostRdData | output | 32 | Descriptor word at hostRdIdx |
| memAddr | output | 16 | Buffer byte address |
| memData | input | 8 | Byte returned for memAddr in the same cycle |
| txValid | output | 1 | Byte offered to the engine |
| txData | output | 8 | Byte to the engine |
| txLast | output | 1 | Final byte of the frame |
| txCrc | output | 1 | Append-CRC request for this buffer |
| txReady | input | 1 | Engine accepts the byte |
| frmDone | input | 1 | Engine reports frame completion or collision abort |
| frmStat | input | 4 | Frame status written on completion |
| bufIrq | output | 1 | Masked buffer-done event |
| frmIrq | output | 1 | Masked frame-done event |
| stopDone | output | 1 | Graceful stop completed |

## Verification
The hardest case to reach is a graceful-stop request that arrives while the first, non-final buffer of a multi-buffer frame is still streaming. A later ready descriptor is queued behind that frame. The bench stalls the engine handshake with a pseudo-random ready pattern so the frame stays open. It raises the stop request as soon as the first byte has been accepted. It then checks that the second buffer still streams, that stopDone pulses only after the engine's completion, and that the queued descriptor stays untouched until the request drops. Halt and restart are reached by leaving the descriptor after a frame not ready and later strobing descActive.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 8;
  localparam int STAT_W = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              ready;
    logic              wrap;
    logic              last;
    logic              crc;
    logic [STAT_W-1:0] stat;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef struct packed {
    logic fetch;
    logic beat;
    logic wbMid;
    logic wbLast;
  } ctl_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_STREAM,
    S_MIDWB,
    S_WAITF
  } seq_state_t;
endpackage

// File: rtl/txbd_ctrl.sv
module txbd_ctrl
  import txdesc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        descActive,
  input  logic        gracefulStop,
  input  logic        bufIrqEn,
  input  logic        frmIrqEn,
  input  logic        txReady,
  input  logic        frmDone,
  input  logic        headReady,
  input  logic        endOfBuf,
  input  logic        curIsLast,
  output ctl_strobe_t stb,
  output logic        txValid,
  output logic        txLast,
  output logic        bufIrq,
  output logic        frmIrq,
  output logic        stopDone
);
  seq_state_t state, nxt;
  logic activeFlag, stopped;
  logic clrAct, stopHit;

  always_comb begin
    stb     = '0;
    nxt     = state;
    clrAct  = 1'b0;
    stopHit = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (gracefulStop) begin
          if (!stopped) stopHit = 1'b1;
        end else if (enable && activeFlag) begin
          nxt = S_FETCH;
        end
      end
      S_FETCH: begin
        if (headReady) begin
          stb.fetch = 1'b1;
          nxt       = S_STREAM;
        end else begin
          clrAct = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_STREAM: begin
        if (txReady) begin
          stb.beat = 1'b1;
          if (endOfBuf) nxt = curIsLast ? S_WAITF : S_MIDWB;
        end
      end
      S_MIDWB: begin
        stb.wbMid = 1'b1;
        nxt       = S_FETCH;
      end
      S_WAITF: begin
        if (frmDone) begin
          stb.wbLast = 1'b1;
          nxt        = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign txValid = (state == S_STREAM);
  assign txLast  = txValid && endOfBuf && curIsLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      activeFlag <= 1'b0;
      stopped    <= 1'b0;
      stopDone   <= 1'b0;
      bufIrq     <= 1'b0;
      frmIrq     <= 1'b0;
    end else begin
      state <= nxt;
      if (descActive)  activeFlag <= 1'b1;
      else if (clrAct) activeFlag <= 1'b0;
      stopped  <= gracefulStop && (stopped || stopHit);
      stopDone <= stopHit;
      bufIrq   <= (stb.wbMid || stb.wbLast) && bufIrqEn;
      frmIrq   <= stb.wbLast && frmIrqEn;
    end
  end
endmodule

// File: rtl/txbd_datapath.sv
module txbd_datapath
  import txdesc_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       stb,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrIdx,
  input  logic [DESC_W-1:0] hostWrData,
  input  logic [IDX_W-1:0]  hostRdIdx,
  output logic [DESC_W-1:0] hostRdData,
  input  logic [STAT_W-1:0] frmStat,
  output logic [ADDR_W-1:0] memAddr,
  output logic              headReady,
  output logic              endOfBuf,
  output logic              curIsLast,
  output logic              curCrc
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  desc_t            ring [DEPTH];
  desc_t            curD;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] cnt;
  logic             wbAny;

  assign wbAny      = stb.wbMid || stb.wbLast;
  assign headReady  = ring[idx].ready;
  assign hostRdData = ring[hostRdIdx];
  assign memAddr    = curD.addr + ADDR_W'(cnt);
  assign endOfBuf   = (cnt == curD.len - 1'b1);
  assign curIsLast  = curD.last;
  assign curCrc     = curD.crc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (wbAny) begin
      ring[idx].ready <= 1'b0;
      if (stb.wbLast) ring[idx].stat <= frmStat;
    end else if (hostWrEn) begin
      ring[hostWrIdx] <= desc_t'(hostWrData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curD <= '0;
      cnt  <= '0;
      idx  <= '0;
    end else begin
      if (stb.fetch) begin
        curD <= ring[idx];
        cnt  <= '0;
      end else if (stb.beat) begin
        cnt <= cnt + 1'b1;
      end
      if (wbAny) begin
        if (curD.wrap || idx == LAST_IDX) idx <= '0;
        else                              idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txbd_sequencer.sv
module txbd_sequencer
  import txdesc_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              descActive,
  input  logic              gracefulStop,
  input  logic              bufIrqEn,
  input  logic              frmIrqEn,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrIdx,
  input  logic [DESC_W-1:0] hostWrData,
  input  logic [IDX_W-1:0]  hostRdIdx,
  output logic [DESC_W-1:0] hostRdData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memData,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  output logic              txLast,
  output logic              txCrc,
  input  logic              txReady,
  input  logic              frmDone,
  input  logic [STAT_W-1:0] frmStat,
  output logic              bufIrq,
  output logic              frmIrq,
  output logic              stopDone
);
  ctl_strobe_t stb;
  logic headReady, endOfBuf, curIsLast;

  assign txData = memData;

  txbd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .descActive(descActive),
    .gracefulStop(gracefulStop), .bufIrqEn(bufIrqEn), .frmIrqEn(frmIrqEn),
    .txReady(txReady), .frmDone(frmDone), .headReady(headReady),
    .endOfBuf(endOfBuf), .curIsLast(curIsLast), .stb(stb),
    .txValid(txValid), .txLast(txLast), .bufIrq(bufIrq),
    .frmIrq(frmIrq), .stopDone(stopDone)
  );

  txbd_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrEn(hostWrEn),
    .hostWrIdx(hostWrIdx), .hostWrData(hostWrData), .hostRdIdx(hostRdIdx),
    .hostRdData(hostRdData), .frmStat(frmStat), .memAddr(memAddr),
    .headReady(headReady), .endOfBuf(endOfBuf), .curIsLast(curIsLast),
    .curCrc(txCrc)
  );
endmodule

// File: rtl/txbd_sequencer_sva.sv
module txbd_sequencer_sva
  import txdesc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic              txLast,
  input logic [ADDR_W-1:0] memAddr,
  input logic              bufIrq,
  input logic              frmIrq,
  input logic              bufIrqEn,
  input logic              frmIrqEn,
  input logic              stopDone,
  input logic              frmDone
);
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(memAddr));

  p_last_in_beat_r4: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  p_frame_irq_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    frmIrq |-> $past(frmDone));

  p_bufirq_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    bufIrq |-> $past(bufIrqEn));

  p_frmirq_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    frmIrq |-> $past(frmIrqEn));

  p_stop_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopDone |=> !stopDone);
endmodule

bind txbd_sequencer txbd_sequencer_sva u_sva (.*);

// File: tb/txbd_sequencer_tb.sv
module txbd_sequencer_tb;
  import txdesc_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, enable = 1'b0, descActive = 1'b0, gracefulStop = 1'b0;
  logic bufIrqEn = 1'b1, frmIrqEn = 1'b1, hostWrEn = 1'b0;
  logic [2:0] hostWrIdx = '0, hostRdIdx = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic [15:0] memAddr;
  logic [7:0] memData, txData;
  logic txValid, txLast, txCrc, bufIrq, frmIrq, stopDone;
  logic txReady = 1'b1, frmDone = 1'b0;
  logic [3:0] frmStat = 4'h0;

  assign memData = memAddr[7:0] ^ memAddr[15:8] ^ 8'h3C;

  txbd_sequencer u_dut (.*);

  int vectors = 0, miscompares = 0;
  int nBytes = 0, cntBuf = 0, cntFrm = 0, cntStop = 0;
  int doneCnt = 0;
  logic stallEn = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [9:0] expQ[$];

  function automatic logic [7:0] byteAt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mk(input logic rdy, wrp, lst, crc,
      input logic [3:0] st, input logic [7:0] len, input logic [15:0] addr);
    return {rdy, wrp, lst, crc, st, len, addr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushBuf(input logic [15:0] addr, input int len, input logic lst, input logic crc);
    for (int k = 0; k < len; k++)
      expQ.push_back({crc, lst && (k == len - 1), byteAt(addr + 16'(k))});
  endtask

  task automatic wrDesc(input int i, input logic [31:0] w);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrIdx = 3'(i); hostWrData = w;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdDesc(input int i, input string tag, input logic [31:0] exp);
    @(negedge clk);
    hostRdIdx = 3'(i);
    #1;
    chk(tag, hostRdData, exp);
  endtask

  task automatic strobeActive();
    @(negedge clk); descActive = 1'b1;
    @(negedge clk); descActive = 1'b0;
  endtask

  task automatic settle(input string tag);
    int t;
    t = 0;
    while ((expQ.size() != 0 || doneCnt != 0 || frmDone) && t < 3000) begin
      @(negedge clk); t++;
    end
    if (t >= 3000) begin
      miscompares++;
      $display("FAIL %s timeout actual=%0d expected=0 pending", tag, expQ.size());
    end
    repeat (8) @(negedge clk);
  endtask

  // Monitor: engine model and scoreboard
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    txReady = stallEn ? lfsr[0] : 1'b1;
    frmDone = 1'b0;
    if (doneCnt != 0) begin
      doneCnt--;
      if (doneCnt == 0) frmDone = 1'b1;
    end
    #1;
    if (rstN && txValid && (doneCnt != 0 || frmDone)) begin
      miscompares++;
      $display("FAIL R6 byte offered before frmDone actual=%h expected=none", txData);
    end
    if (rstN && txValid && txReady) begin
      nBytes++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R3 unexpected byte actual=%h expected=none", txData);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        vectors++;
        if ({txCrc, txLast, txData} !== e) begin
          miscompares++;
          $display("FAIL R3/R4 byte actual=%h expected=%h", {txCrc, txLast, txData}, e);
        end
        if (e[8]) doneCnt = 4;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (bufIrq) cntBuf++;
      if (frmIrq) cntFrm++;
      if (stopDone) begin
        cntStop++;
        if (expQ.size() != 0 || doneCnt != 0) begin
          miscompares++;
          $display("FAIL R11 stopDone mid-frame actual=%0d expected=0", expQ.size());
        end
      end
    end
  end

  initial begin
    #1600000;
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int b0, f0, n0, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 events", {29'd0, bufIrq, frmIrq, stopDone}, 0);
    rdDesc(0, "R1 desc0", 0);

    // R2: enable without strobe, then strobe without enable
    wrDesc(0, mk(1, 0, 1, 1, 0, 8'd5, 16'h0100));
    @(negedge clk); enable = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 enable only", nBytes, 0);
    enable = 1'b0;
    strobeActive();
    repeat (20) @(negedge clk);
    chk("R2 strobe only", nBytes, 0);
    pushBuf(16'h0100, 5, 1, 1);
    frmStat = 4'h5;
    enable = 1'b1;
    settle("R2 frame");
    rdDesc(0, "R6 desc0 status", mk(0, 0, 1, 1, 4'h5, 8'd5, 16'h0100));
    chk("R9 bufIrq count", cntBuf, 1);
    chk("R9 frmIrq count", cntFrm, 1);

    // R5 R6 multi-buffer frame with stalls, frame irq masked
    frmIrqEn = 1'b0; stallEn = 1'b1; frmStat = 4'hA;
    wrDesc(1, mk(1, 0, 0, 0, 4'h3, 8'd3, 16'h1200));
    wrDesc(2, mk(1, 0, 1, 0, 0, 8'd4, 16'h2300));
    pushBuf(16'h1200, 3, 0, 0);
    pushBuf(16'h2300, 4, 1, 0);
    strobeActive();
    settle("R5 frame");
    rdDesc(1, "R5 middle only ready cleared", mk(0, 0, 0, 0, 4'h3, 8'd3, 16'h1200));
    rdDesc(2, "R6 last status", mk(0, 0, 1, 0, 4'hA, 8'd4, 16'h2300));
    chk("R9 bufIrq count", cntBuf, 3);
    chk("R9 frmIrq masked", cntFrm, 1);

    // R8 halt, R7 wrap
    frmIrqEn = 1'b1; bufIrqEn = 1'b0;
    wrDesc(3, mk(1, 1, 1, 1, 0, 8'd2, 16'h3400));
    wrDesc(0, mk(1, 0, 1, 0, 0, 8'd3, 16'h4500));
    n0 = nBytes;
    repeat (20) @(negedge clk);
    chk("R8 halted", nBytes, n0);
    frmStat = 4'h6;
    pushBuf(16'h3400, 2, 1, 1);
    pushBuf(16'h4500, 3, 1, 0);
    strobeActive();
    settle("R7 wrap");
    rdDesc(0, "R7 index 0 after wrap", mk(0, 0, 1, 0, 4'h6, 8'd3, 16'h4500));
    rdDesc(3, "R7 wrap desc", mk(0, 1, 1, 1, 4'h6, 8'd2, 16'h3400));
    chk("R9 bufIrq masked", cntBuf, 3);
    chk("R9 frmIrq count", cntFrm, 3);

    // R10 stop while idle
    bufIrqEn = 1'b1;
    s0 = cntStop;
    @(negedge clk); gracefulStop = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 stopDone idle", cntStop, s0 + 1);
    wrDesc(1, mk(1, 0, 1, 1, 0, 8'd2, 16'h5600));
    strobeActive();
    n0 = nBytes;
    repeat (20) @(negedge clk);
    chk("R10 no start while stopped", nBytes, n0);
    chk("R10 single pulse", cntStop, s0 + 1);
    frmStat = 4'h1;
    gracefulStop = 1'b0;
    pushBuf(16'h5600, 2, 1, 1);
    settle("R11 resume");
    rdDesc(1, "R11 resumed desc", mk(0, 0, 1, 1, 4'h1, 8'd2, 16'h5600));

    // R11 stop raised in the middle of a multi-buffer frame
    wrDesc(2, mk(1, 0, 0, 1, 0, 8'd6, 16'h6700));
    wrDesc(3, mk(1, 0, 1, 1, 0, 8'd2, 16'h7800));
    wrDesc(4, mk(1, 0, 1, 0, 0, 8'd3, 16'h8900));
    pushBuf(16'h6700, 6, 0, 1);
    pushBuf(16'h7800, 2, 1, 1);
    frmStat = 4'hC;
    s0 = cntStop; n0 = nBytes;
    strobeActive();
    while (nBytes == n0) @(negedge clk);
    gracefulStop = 1'b1;
    settle("R11 frame");
    chk("R11 stopDone after frame", cntStop, s0 + 1);
    n0 = nBytes;
    repeat (20) @(negedge clk);
    chk("R11 parked", nBytes, n0);
    rdDesc(4, "R11 next untouched", mk(1, 0, 1, 0, 0, 8'd3, 16'h8900));
    rdDesc(3, "R11 frame status", mk(0, 0, 1, 1, 4'hC, 8'd2, 16'h7800));
    frmStat = 4'h2;
    gracefulStop = 1'b0;
    pushBuf(16'h8900, 3, 1, 0);
    settle("R11 resume next");
    rdDesc(4, "R11 next sent", mk(0, 0, 1, 0, 4'h2, 8'd3, 16'h8900));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule